// File: doc/BRIEF.md
# Multi-format serial audio receiver

The receiver turns a stereo serial audio stream into parallel samples. The stream arrives on three wires: a bit clock, a word clock that marks which channel is being sent, and serial data. All three are brought into the system clock domain and oversampled there. Each rising edge of the bit clock shifts one data bit into a single capture engine. A 3-bit format code tells the engine where each word sits inside its half of the frame.

The engine handles five framings:

- right-justified words of 16, 20 or 24 bits;
- left-justified 24-bit words;
- I2S.

Right-justified words are taken from the last N bits before a word-clock change. Left-justified and I2S words are taken from the first 24 bits of each half. Every word is sign-extended to 24 bits. Once the right word of a frame is complete, both channel samples are presented together with a one-cycle valid pulse.

The format code is the bitwise OR of two 3-bit inputs. One is meant for strap pins and the other for a control register.

Top module: `ser_audio_rx`

## Requirements
- R1: Effective code 000 captures, for each channel, the 16 bits sampled just before the word-clock change (last bit = LSB) and sign-extends them from bit 15.
- R2: Effective code 001 does the same with the last 20 bits, sign-extended from bit 19.
- R3: Effective code 100 does the same with the last 24 bits.
- R4: Effective code 010 (left-justified) takes the bit sampled at the first bit-clock rise after the word-clock change as the MSB, takes 24 bits, and ignores any later bits in that half. A 16-bit source padded with zero low bits is returned as a 24-bit word with those low bits zero.
- R5: Effective code 011 (I2S) takes the MSB one bit-clock period after the word-clock change. A low word clock marks the left channel. In all other modes a high word clock marks the left channel.
- R6: Effective codes 101, 110 and 111 behave exactly as code 000.
- R7: The effective code is the bitwise OR of fmt_pin_i and fmt_reg_i.
- R8: valid_o is high for exactly one clock per complete stereo frame, after the right word ends. left_o and right_o change only in that cycle and hold otherwise.
- R9: In right-justified modes, bits before the MSB in a half have no effect on the sample.
- R10: After reset, left_o and right_o are 0 and valid_o is low. A word is reported only after a word-clock change has been seen, so a partial word at start-up never produces valid_o.
- R11: The minimum bit-clock rates are supported: 16, 20 and 24 bits per half for the 16-bit, 20-bit and 24-bit/I2S modes respectively.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock, faster than the bit clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bclk_i | input | 1 | Serial bit clock; data sampled on its rising edge |
| wclk_i | input | 1 | Word clock (channel select) |
| sdata_i | input | 1 | Serial data, two's complement, MSB first |
| fmt_pin_i | input | 3 | Format code from pins |
| fmt_reg_i | input | 3 | Format code from register bits |
| left_o | output | SAMPLE_W | Left sample, sign-extended |
| right_o | output | SAMPLE_W | Right sample, sign-extended |
| valid_o | output | 1 | One-cycle pulse when a stereo frame is complete |

## Verification
Two actions fall on the same bit-clock rise: the store of the word that just ended, which for the right word also raises valid_o, and the reload of the capture register with the first bit of the new word. At the minimum rate in I2S mode, that same rise also carries the LSB of the ending word. These collisions are provoked by running every mode at its minimum number of bits per half as well as at 32 bits per half. They are judged by comparing each reported frame bit-exactly with words the bench builds and sign-extends itself. The bench also checks on every clock that the outputs do not move outside a valid pulse.

// File: rtl/ser_audio_rx_pkg.sv
package ser_audio_rx_pkg;

  typedef enum logic [2:0] {
    FMT_RJ16 = 3'd0,
    FMT_RJ20 = 3'd1,
    FMT_LJ24 = 3'd2,
    FMT_I2S  = 3'd3,
    FMT_RJ24 = 3'd4
  } fmt_e;

  // unused codes fall back to 16-bit right-justified
  function automatic fmt_e fmt_decode(input logic [2:0] code);
    case (code)
      3'd1:    return FMT_RJ20;
      3'd2:    return FMT_LJ24;
      3'd3:    return FMT_I2S;
      3'd4:    return FMT_RJ24;
      default: return FMT_RJ16;
    endcase
  endfunction

endpackage

// File: rtl/ser_audio_rx_sync.sv
module ser_audio_rx_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  for (genvar gi = 0; gi < WIDTH; gi++) begin : g_bit
    logic [STAGES-1:0] sr;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sr <= '0;
      else         sr <= {sr[STAGES-2:0], d_i[gi]};
    end
    assign q_o[gi] = sr[STAGES-1];
  end

endmodule

// File: rtl/ser_audio_rx_fmt.sv
module ser_audio_rx_fmt
  import ser_audio_rx_pkg::*;
(
  input  logic [2:0] fmt_pin_i,
  input  logic [2:0] fmt_reg_i,
  output fmt_e       mode_o
);

  assign mode_o = fmt_decode(fmt_pin_i | fmt_reg_i);

endmodule

// File: rtl/ser_audio_rx_core.sv
module ser_audio_rx_core
  import ser_audio_rx_pkg::*;
#(
  parameter int W = 24
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         rise_i,
  input  logic         ws_i,
  input  logic         sd_i,
  input  fmt_e         mode_i,
  output logic [W-1:0] left_o,
  output logic [W-1:0] right_o,
  output logic         valid_o
);

  localparam int CW = $clog2(W + 1);

  logic [W-1:0]  rj_sh, cap, left_q, word;
  logic [CW-1:0] cnt;
  logic [1:0]    primed;
  logic          ws_d, ws_prev, started_q, left_seen;
  logic          ws_eff, trans, ended_left, is_i2s;

  function automatic logic [W-1:0] sext(input logic [W-1:0] v, input int n);
    logic [W-1:0] r;
    for (int i = 0; i < W; i++) r[i] = (i < n) ? v[i] : v[n-1];
    return r;
  endfunction

  // I2S: the word clock is delayed one bit so the MSB lines up like left-justified
  assign is_i2s     = (mode_i == FMT_I2S);
  assign ws_eff     = is_i2s ? ws_d : ws_i;
  assign trans      = primed[1] && (ws_eff != ws_prev);
  assign ended_left = is_i2s ? ~ws_prev : ws_prev;

  always_comb begin
    case (mode_i)
      FMT_RJ16: word = sext(rj_sh, 16);
      FMT_RJ20: word = sext(rj_sh, 20);
      FMT_RJ24: word = rj_sh;
      default:  word = cap;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rj_sh     <= '0;
      cap       <= '0;
      cnt       <= '0;
      primed    <= '0;
      ws_d      <= 1'b0;
      ws_prev   <= 1'b0;
      started_q <= 1'b0;
      left_seen <= 1'b0;
      left_q    <= '0;
      left_o    <= '0;
      right_o   <= '0;
      valid_o   <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (rise_i) begin
        ws_d    <= ws_i;
        ws_prev <= ws_eff;
        primed  <= {primed[0], 1'b1};
        rj_sh   <= {rj_sh[W-2:0], sd_i};
        if (trans) begin
          if (started_q) begin
            if (ended_left) begin
              left_q    <= word;
              left_seen <= 1'b1;
            end else if (left_seen) begin
              left_o    <= left_q;
              right_o   <= word;
              valid_o   <= 1'b1;
              left_seen <= 1'b0;
            end
          end
          started_q <= 1'b1;
          cap       <= {{(W-1){1'b0}}, sd_i};
          cnt       <= CW'(1);
        end else if (cnt < CW'(W)) begin
          cap <= {cap[W-2:0], sd_i};
          cnt <= cnt + CW'(1);
        end
      end
    end
  end

  // R8
  single_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);

  // R8
  out_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(left_o) || !$stable(right_o)) |-> valid_o);

  // R4
  cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt <= CW'(W));

  // R10
  valid_after_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> started_q);

  // R11
  rise_spacing_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_i |=> !rise_i);

endmodule

// File: rtl/ser_audio_rx.sv
module ser_audio_rx
  import ser_audio_rx_pkg::*;
#(
  parameter int SAMPLE_W    = 24,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                bclk_i,
  input  logic                wclk_i,
  input  logic                sdata_i,
  input  logic [2:0]          fmt_pin_i,
  input  logic [2:0]          fmt_reg_i,
  output logic [SAMPLE_W-1:0] left_o,
  output logic [SAMPLE_W-1:0] right_o,
  output logic                valid_o
);

  logic [2:0] sync_q;
  logic       bclk_prev, rise;
  fmt_e       mode;

  ser_audio_rx_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({sdata_i, wclk_i, bclk_i}),
    .q_o    (sync_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) bclk_prev <= 1'b0;
    else         bclk_prev <= sync_q[0];
  end

  assign rise = sync_q[0] & ~bclk_prev;

  ser_audio_rx_fmt u_fmt (
    .fmt_pin_i (fmt_pin_i),
    .fmt_reg_i (fmt_reg_i),
    .mode_o    (mode)
  );

  ser_audio_rx_core #(.W(SAMPLE_W)) u_core (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .rise_i  (rise),
    .ws_i    (sync_q[1]),
    .sd_i    (sync_q[2]),
    .mode_i  (mode),
    .left_o  (left_o),
    .right_o (right_o),
    .valid_o (valid_o)
  );

endmodule

// File: tb/ser_audio_rx_tb.sv
`timescale 1ns/1ps
module ser_audio_rx_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bclk = 1'b0, wclk = 1'b0, sdata = 1'b0;
  logic [2:0]  fpin = 3'd0, freg = 3'd0;
  logic [23:0] left_o, right_o;
  logic        valid_o;

  int          checks = 0, errors = 0, cycles = 0;
  bit          in_reset = 1'b1, done = 1'b0;
  bit          i2s, rj;
  logic        prev_bit;
  logic [23:0] q_l[$], q_r[$];
  logic [23:0] held_l = '0, held_r = '0;
  string       cur_req = "R1";
  logic [31:0] lcg = 32'h1234_5678;

  always #5 clk = ~clk;

  ser_audio_rx u_dut (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .bclk_i    (bclk),
    .wclk_i    (wclk),
    .sdata_i   (sdata),
    .fmt_pin_i (fpin),
    .fmt_reg_i (freg),
    .left_o    (left_o),
    .right_o   (right_o),
    .valid_o   (valid_o)
  );

  function automatic logic [23:0] sx(input logic [23:0] v, input int n);
    logic [23:0] m = (n >= 24) ? 24'hFFFFFF : ((24'd1 << n) - 24'd1);
    return (v[n-1]) ? (v | ~m) : (v & m);
  endfunction

  // reference comparison on every clock
  always @(negedge clk) begin
    if (!in_reset && !done) begin
      checks++;
      if (valid_o) begin
        if (q_l.size() == 0) begin
          errors++;
          $display("FAIL R8 unexpected valid: actual L=%h R=%h expected no frame", left_o, right_o);
        end else begin
          logic [23:0] el, er;
          el = q_l.pop_front();
          er = q_r.pop_front();
          if (left_o !== el || right_o !== er) begin
            errors++;
            $display("FAIL %s frame: actual L=%h R=%h expected L=%h R=%h",
                     cur_req, left_o, right_o, el, er);
          end
          held_l = el;
          held_r = er;
        end
      end else if (left_o !== held_l || right_o !== held_r) begin
        errors++;
        $display("FAIL R8 hold: actual L=%h R=%h expected L=%h R=%h",
                 left_o, right_o, held_l, held_r);
      end
    end
  end

  task automatic send_slot(input logic ws, input logic b);
    logic db;
    db = i2s ? prev_bit : b;
    prev_bit = b;
    @(negedge clk);
    bclk = 1'b0; wclk = ws; sdata = db;
    repeat (4) @(negedge clk);
    bclk = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic send_half(input logic ws, input logic [23:0] word, input int half, input int n);
    for (int k = 0; k < half; k++) begin
      logic b;
      if (rj) b = (k >= half - n) ? word[half-1-k] : k[0];
      else    b = (k < 24) ? word[23-k] : ~k[0];
      send_slot(ws, b);
    end
  endtask

  task automatic run(input logic [2:0] p, input logic [2:0] r, input int mode,
                     input int half, input int nfr, input bit lj16, input string tag);
    int   n;
    logic wl;
    in_reset = 1'b1;
    rst_n = 1'b0;
    fpin = p; freg = r;
    bclk = 1'b0; sdata = 1'b0;
    n   = (mode == 0) ? 16 : (mode == 1) ? 20 : 24;
    i2s = (mode == 3);
    rj  = (mode == 0) || (mode == 1) || (mode == 4);
    wl  = i2s ? 1'b0 : 1'b1;
    wclk = ~wl;
    repeat (3) @(negedge clk);
    checks++;
    if (left_o !== 24'd0 || right_o !== 24'd0 || valid_o !== 1'b0) begin
      errors++;
      $display("FAIL R10 reset: actual L=%h R=%h V=%b expected 0 0 0", left_o, right_o, valid_o);
    end
    q_l.delete(); q_r.delete();
    held_l = '0; held_r = '0;
    cur_req = tag;
    rst_n = 1'b1;
    @(negedge clk);
    in_reset = 1'b0;
    prev_bit = 1'b0;
    // partial right-channel preroll must not produce a frame (R10)
    for (int k = 0; k < 4; k++) send_slot(~wl, 1'b1);
    for (int f = 0; f < nfr; f++) begin
      logic [23:0] wlft, wrgt;
      lcg = lcg * 32'd1664525 + 32'd1013904223;
      wlft = lcg[31:8];
      lcg = lcg * 32'd1664525 + 32'd1013904223;
      wrgt = lcg[31:8];
      if (lj16) begin
        wlft = {wlft[23:8], 8'd0};
        wrgt = {wrgt[23:8], 8'd0};
      end
      if (f == 0) begin
        wlft[n-1] = 1'b1;
        wrgt[n-1] = 1'b0;
      end
      if (rj) begin
        q_l.push_back(sx(wlft, n));
        q_r.push_back(sx(wrgt, n));
      end else begin
        q_l.push_back(wlft);
        q_r.push_back(wrgt);
      end
      send_half(wl, wlft, half, n);
      send_half(~wl, wrgt, half, n);
    end
    send_half(wl, 24'd0, half, n);
    repeat (20) @(negedge clk);
    checks++;
    if (q_l.size() != 0) begin
      errors++;
      $display("FAIL R8 frame count %s: actual %0d missing expected 0", tag, q_l.size());
    end
  endtask

  initial begin
    run(3'b000, 3'b000, 0, 32, 3, 1'b0, "R1");
    run(3'b000, 3'b000, 0, 16, 3, 1'b0, "R11");
    run(3'b000, 3'b001, 1, 32, 3, 1'b0, "R2");
    run(3'b001, 3'b000, 1, 20, 3, 1'b0, "R11");
    run(3'b100, 3'b000, 4, 32, 3, 1'b0, "R3");
    run(3'b000, 3'b100, 4, 24, 3, 1'b0, "R11");
    run(3'b010, 3'b000, 2, 32, 3, 1'b0, "R4");
    run(3'b010, 3'b000, 2, 32, 2, 1'b1, "R4");
    run(3'b010, 3'b000, 2, 24, 3, 1'b0, "R11");
    run(3'b011, 3'b000, 3, 32, 3, 1'b0, "R5");
    run(3'b000, 3'b011, 3, 24, 3, 1'b0, "R11");
    run(3'b101, 3'b000, 0, 32, 2, 1'b0, "R6");
    run(3'b110, 3'b000, 0, 16, 2, 1'b0, "R6");
    run(3'b000, 3'b111, 0, 32, 2, 1'b0, "R6");
    run(3'b001, 3'b010, 3, 32, 2, 1'b0, "R7");
    run(3'b100, 3'b000, 4, 32, 2, 1'b0, "R9");
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000 && !done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule